// File: doc/BRIEF.md
# UART transceiver with selectable parity

This block is a full-duplex asynchronous serial transceiver. It has one transmit line and one receive line, and one clock divisor sets the bit time for both. The divisor loads at reset with the integer quotient of the clock frequency over the baud rate. User logic can rewrite it at any time through a single write strobe. Each frame is one low start bit, eight data bits sent least significant bit first, an optional parity bit and one high stop bit. The line idles high.

The user logic moves bytes through two ready/acknowledge handshakes. On the transmit side, `tx_rdy` means the serializer is idle. If `tx_ack` is high while `tx_rdy` is high, the byte on `tx_data` is taken in that cycle and its frame begins. On the receive side, `rx_rdy` presents a byte together with a three-bit error vector. Both stay frozen until `rx_ack`. The receive line passes through a two-flop synchronizer. A falling edge is confirmed as a start bit half a bit later, and every later bit is sampled at its centre.

The parity selector offers five modes: none, mark, space, even and odd. Errors are reported with the byte they belong to. A frame error means the stop bit was low. A parity error means the received parity bit disagreed with the selected mode. An overrun means a frame completed while the previous byte was still unacknowledged.

Top module: `uart_xcvr`

## Requirements
- R1: After reset `txd` is 1, `tx_rdy` is 1, `rx_rdy` is 0 and `div_value` equals CLK_HZ/BAUD (16 with default parameters).
- R2: A cycle with `div_we` high makes `div_value` equal `div_wdata` on the next cycle; otherwise `div_value` keeps its value. Every transmitted bit lasts `div_value` clocks.
- R3: When `tx_ack` and `tx_rdy` are both high at a clock edge, `tx_data` is captured, `tx_rdy` is 0 and `txd` is 0 (start bit) from the next cycle. `tx_ack` while `tx_rdy` is 0 has no effect on the frame in flight and starts no new frame.
- R4: A transmitted frame is start 0, data bit 0 through bit 7, the parity bit if enabled, then stop 1. `txd` is 1 whenever `tx_rdy` is 1, and `tx_rdy` returns right after the stop bit.
- R5: `parity_sel` encoding: 0 none, 1 mark (bit is always 1), 2 space (always 0), 3 even (data ones plus parity bit is even), 4 odd (that total is odd). Codes 5 to 7 behave as none.
- R6: The receiver confirms a start bit only if the synchronized line is still low half a bit period after the falling edge. A low pulse shorter than that produces no byte.
- R7: While `rx_rdy` is 1 and `rx_ack` is 0, `rx_rdy`, `rx_data` and `rx_err` hold. `rx_ack` with `rx_rdy` clears `rx_rdy` on the next cycle.
- R8: `rx_err` bit 0 (frame) is 1 when the stop bit is sampled low. The data byte is still delivered.
- R9: `rx_err` bit 1 (parity) is 1 when the received parity bit differs from the value the selected mode expects.
- R10: A frame completing while `rx_rdy` is 1 and unacknowledged is discarded, and the held byte is unchanged. The next byte delivered carries `rx_err` bit 2 (overrun) set, and that bit is clear again on the byte after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_we | input | 1 | Divisor write strobe |
| div_wdata | input | DIV_W | New divisor value |
| div_value | output | DIV_W | Current divisor (clocks per bit) |
| parity_sel | input | 3 | Parity mode, encoding as in R5 |
| tx_data | input | DATA_W | Byte offered for transmission |
| tx_ack | input | 1 | User offers `tx_data` |
| tx_rdy | output | 1 | Transmitter idle, can take a byte |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line (asynchronous) |
| rx_data | output | DATA_W | Received byte |
| rx_err | output | 3 | Error flags: bit 2 overrun, bit 1 parity, bit 0 frame |
| rx_rdy | output | 1 | Received byte and flags valid |
| rx_ack | input | 1 | User consumes the received byte |

## Verification
A corrupted transmit bit counter or shift register shows up on `txd` within one bit period, because the bench predicts the line level on every clock of the frame. A receive state error, such as wrong start qualification, off-centre sampling or a lost overrun flag, shows up at the next `rx_rdy` as a wrong byte or wrong flag vector, or as a byte that should not exist. That is at most one frame time after the faulty stimulus. Holding violations on the receive side appear within a few cycles, because the bench watches the held outputs before it acknowledges.

// File: rtl/uart_xcvr_pkg.sv
package uart_xcvr_pkg;

    localparam int ERR_W = 3;

    localparam logic [2:0] PAR_NONE  = 3'd0;
    localparam logic [2:0] PAR_MARK  = 3'd1;
    localparam logic [2:0] PAR_SPACE = 3'd2;
    localparam logic [2:0] PAR_EVEN  = 3'd3;
    localparam logic [2:0] PAR_ODD   = 3'd4;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_PAR,
        FR_STOP
    } frame_st_e;

    typedef struct packed {
        logic ovr;
        logic par;
        logic frm;
    } rx_err_t;

    function automatic logic par_enabled(input logic [2:0] sel);
        return (sel == PAR_MARK) || (sel == PAR_SPACE) ||
               (sel == PAR_EVEN) || (sel == PAR_ODD);
    endfunction

    // odd_ones: reduction XOR of the data byte
    function automatic logic par_expected(input logic [2:0] sel, input logic odd_ones);
        case (sel)
            PAR_MARK:  return 1'b1;
            PAR_SPACE: return 1'b0;
            PAR_EVEN:  return odd_ones;
            PAR_ODD:   return ~odd_ones;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/uart_sync.sv
module uart_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= 1'b1;
                else        chain_q <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_xcvr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div,
    input  logic [2:0]        parity_sel,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_ack,
    output logic              tx_rdy,
    output logic              txd
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    typedef struct packed {
        frame_st_e         st;
        logic [DIV_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] sh;
        logic              pbit;
        logic              line;
    } tx_state_t;

    tx_state_t s_d, s_q;
    logic      tick;

    always_comb begin
        s_d  = s_q;
        tick = (s_q.cnt == '0);
        if (s_q.st != FR_IDLE) begin
            s_d.cnt = tick ? (div - 1'b1) : (s_q.cnt - 1'b1);
        end
        case (s_q.st)
            FR_IDLE: begin
                if (tx_ack) begin
                    s_d.st   = FR_START;
                    s_d.line = 1'b0;
                    s_d.cnt  = div - 1'b1;
                    s_d.sh   = tx_data;
                    s_d.idx  = '0;
                    s_d.pbit = par_expected(parity_sel, ^tx_data);
                end
            end
            FR_START: begin
                if (tick) begin
                    s_d.st   = FR_DATA;
                    s_d.line = s_q.sh[0];
                end
            end
            FR_DATA: begin
                if (tick) begin
                    if (s_q.idx == LAST_IDX) begin
                        if (par_enabled(parity_sel)) begin
                            s_d.st   = FR_PAR;
                            s_d.line = s_q.pbit;
                        end else begin
                            s_d.st   = FR_STOP;
                            s_d.line = 1'b1;
                        end
                    end else begin
                        s_d.idx  = s_q.idx + 1'b1;
                        s_d.sh   = s_q.sh >> 1;
                        s_d.line = s_q.sh[1];
                    end
                end
            end
            FR_PAR: begin
                if (tick) begin
                    s_d.st   = FR_STOP;
                    s_d.line = 1'b1;
                end
            end
            FR_STOP: begin
                if (tick) begin
                    s_d.st  = FR_IDLE;
                    s_d.cnt = '0;
                end
            end
            default: s_d.st = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= FR_IDLE;
            s_q.line <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_rdy = (s_q.st == FR_IDLE);
    assign txd    = s_q.line;
endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_xcvr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div,
    input  logic [2:0]        parity_sel,
    input  logic              line,
    input  logic              rx_ack,
    output logic [DATA_W-1:0] rx_data,
    output rx_err_t           rx_err,
    output logic              rx_rdy
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    typedef struct packed {
        frame_st_e         st;
        logic [DIV_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] sh;
        logic              prev;
        logic              perr;
        logic              ovr_pend;
        logic [DATA_W-1:0] data;
        rx_err_t           err;
        logic              rdy;
    } rx_state_t;

    rx_state_t s_d, s_q;
    logic      tick;

    always_comb begin
        s_d      = s_q;
        s_d.prev = line;
        tick     = (s_q.cnt == '0);
        if (s_q.st != FR_IDLE && !tick) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
        if (s_q.rdy && rx_ack) begin
            s_d.rdy = 1'b0;
        end
        case (s_q.st)
            FR_IDLE: begin
                if (s_q.prev && !line) begin
                    s_d.st  = FR_START;
                    s_d.cnt = (div >> 1) - 1'b1;
                end
            end
            FR_START: begin
                if (tick) begin
                    if (!line) begin
                        s_d.st   = FR_DATA;
                        s_d.cnt  = div - 1'b1;
                        s_d.idx  = '0;
                        s_d.perr = 1'b0;
                    end else begin
                        s_d.st = FR_IDLE;
                    end
                end
            end
            FR_DATA: begin
                if (tick) begin
                    s_d.sh  = {line, s_q.sh[DATA_W-1:1]};
                    s_d.cnt = div - 1'b1;
                    if (s_q.idx == LAST_IDX) begin
                        s_d.st = par_enabled(parity_sel) ? FR_PAR : FR_STOP;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            FR_PAR: begin
                if (tick) begin
                    s_d.perr = (line != par_expected(parity_sel, ^s_q.sh));
                    s_d.st   = FR_STOP;
                    s_d.cnt  = div - 1'b1;
                end
            end
            FR_STOP: begin
                if (tick) begin
                    s_d.st  = FR_IDLE;
                    s_d.cnt = '0;
                    if (s_q.rdy && !rx_ack) begin
                        s_d.ovr_pend = 1'b1;
                    end else begin
                        s_d.rdy      = 1'b1;
                        s_d.data     = s_q.sh;
                        s_d.err.ovr  = s_q.ovr_pend;
                        s_d.err.par  = s_q.perr;
                        s_d.err.frm  = !line;
                        s_d.ovr_pend = 1'b0;
                    end
                end
            end
            default: s_d.st = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= FR_IDLE;
            s_q.prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign rx_data = s_q.data;
    assign rx_err  = s_q.err;
    assign rx_rdy  = s_q.rdy;
endmodule

// File: rtl/uart_xcvr.sv
module uart_xcvr
    import uart_xcvr_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int BAUD        = 3_125_000,
    parameter int DIV_RESET   = CLK_HZ / BAUD,
    parameter int DIV_W       = $clog2(DIV_RESET + 1),
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_we,
    input  logic [DIV_W-1:0]  div_wdata,
    output logic [DIV_W-1:0]  div_value,
    input  logic [2:0]        parity_sel,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_ack,
    output logic              tx_rdy,
    output logic              txd,
    input  logic              rxd,
    output logic [DATA_W-1:0] rx_data,
    output logic [ERR_W-1:0]  rx_err,
    output logic              rx_rdy,
    input  logic              rx_ack
);
    localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(DIV_RESET);

    logic [DIV_W-1:0] div_d, div_q;
    logic             rx_line;
    rx_err_t          rx_err_s;

    always_comb begin
        div_d = div_q;
        if (div_we) div_d = div_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= DIV_INIT;
        else        div_q <= div_d;
    end

    assign div_value = div_q;

    uart_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rx_line)
    );

    uart_tx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .div       (div_q),
        .parity_sel(parity_sel),
        .tx_data   (tx_data),
        .tx_ack    (tx_ack),
        .tx_rdy    (tx_rdy),
        .txd       (txd)
    );

    uart_rx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .div       (div_q),
        .parity_sel(parity_sel),
        .line      (rx_line),
        .rx_ack    (rx_ack),
        .rx_data   (rx_data),
        .rx_err    (rx_err_s),
        .rx_rdy    (rx_rdy)
    );

    assign rx_err = rx_err_s;
endmodule

// File: rtl/uart_xcvr_chk.sv
module uart_xcvr_chk #(
    parameter int DIV_W  = 5,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              div_we,
    input logic [DIV_W-1:0]  div_wdata,
    input logic [DIV_W-1:0]  div_value,
    input logic              tx_ack,
    input logic              tx_rdy,
    input logic              txd,
    input logic [DATA_W-1:0] rx_data,
    input logic [2:0]        rx_err,
    input logic              rx_rdy,
    input logic              rx_ack
);
    p_div_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        div_we |=> div_value == $past(div_wdata));

    p_div_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !div_we |=> $stable(div_value));

    p_tx_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rdy && tx_ack |=> !tx_rdy && !txd);

    p_idle_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rdy |-> txd);

    p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rdy && !rx_ack |=> rx_rdy && $stable(rx_data) && $stable(rx_err));
endmodule

bind uart_xcvr uart_xcvr_chk #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .div_we   (div_we),
    .div_wdata(div_wdata),
    .div_value(div_value),
    .tx_ack   (tx_ack),
    .tx_rdy   (tx_rdy),
    .txd      (txd),
    .rx_data  (rx_data),
    .rx_err   (rx_err),
    .rx_rdy   (rx_rdy),
    .rx_ack   (rx_ack)
);

// File: tb/uart_xcvr_tb.sv
module uart_xcvr_tb;
    localparam int DW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          div_we = 1'b0;
    logic [DW-1:0] div_wdata = '0;
    logic [DW-1:0] div_value;
    logic [2:0]    parity_sel = 3'd0;
    logic [7:0]    tx_data = '0;
    logic          tx_ack = 1'b0;
    logic          tx_rdy, txd, rx_rdy;
    logic          rx_ack = 1'b0;
    logic [7:0]    rx_data;
    logic [2:0]    rx_err;
    logic          loop_en = 1'b1;
    logic          drv_rxd = 1'b1;
    logic          rxd;

    int checks = 0;
    int fails = 0;
    int cur_div = 16;
    bit finished = 0;

    always #10 clk = ~clk;
    assign rxd = loop_en ? txd : drv_rxd;

    uart_xcvr u_dut (
        .clk(clk), .rst_n(rst_n), .div_we(div_we), .div_wdata(div_wdata),
        .div_value(div_value), .parity_sel(parity_sel), .tx_data(tx_data),
        .tx_ack(tx_ack), .tx_rdy(tx_rdy), .txd(txd), .rxd(rxd),
        .rx_data(rx_data), .rx_err(rx_err), .rx_rdy(rx_rdy), .rx_ack(rx_ack)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // -1 means no parity bit
    function automatic int ref_par(input int mode, input logic [7:0] b);
        case (mode)
            1: return 1;
            2: return 0;
            3: return int'(^b);
            4: return int'(~^b);
            default: return -1;
        endcase
    endfunction

    // Sends a byte and compares txd on every clock against the expected frame
    task automatic tx_frame(input logic [7:0] b, input bit poke_busy);
        logic bits [11];
        int nb;
        int p;
        int bad_at;
        logic seen;
        @(negedge clk);
        chk(tx_rdy === 1'b1, "R3", "tx_rdy before offer", tx_rdy, 1);
        tx_data = b;
        tx_ack  = 1'b1;
        @(negedge clk);
        tx_ack  = 1'b0;
        bits[0] = 1'b0;
        for (int i = 0; i < 8; i++) bits[i+1] = b[i];
        p  = ref_par(int'(parity_sel), b);
        nb = 9;
        if (p >= 0) begin
            bits[nb] = p[0];
            nb++;
        end
        bits[nb] = 1'b1;
        nb++;
        bad_at = -1;
        seen = 1'b0;
        for (int i = 0; i < nb; i++) begin
            for (int k = 0; k < cur_div; k++) begin
                if (txd !== bits[i] && bad_at < 0) begin
                    bad_at = i;
                    seen = txd;
                end
                if (tx_rdy !== 1'b0 && bad_at < 0) bad_at = 100 + i;
                if (poke_busy && i == 3 && k == 0) begin
                    tx_data = 8'hFF;
                    tx_ack  = 1'b1;
                end else begin
                    tx_ack = 1'b0;
                end
                @(negedge clk);
            end
        end
        tx_ack = 1'b0;
        chk(bad_at < 0, "R4 R5", $sformatf("frame %0h mode %0d bit %0d", b, parity_sel, bad_at),
            seen, (bad_at >= 0 && bad_at < 11) ? bits[bad_at] : 1'b0);
        chk(tx_rdy === 1'b1 && txd === 1'b1, "R4", "idle after stop", {tx_rdy, txd}, 2'b11);
        if (poke_busy) begin
            bad_at = 0;
            for (int k = 0; k < 3 * cur_div; k++) begin
                if (txd !== 1'b1) bad_at = 1;
                @(negedge clk);
            end
            chk(bad_at == 0, "R3", "offer while busy started a frame", bad_at, 0);
        end
    endtask

    task automatic drive_frame(input logic [7:0] b, input bit flip_par, input logic stop_v);
        int p;
        p = ref_par(int'(parity_sel), b);
        drv_rxd = 1'b0;
        repeat (cur_div) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            drv_rxd = b[i];
            repeat (cur_div) @(negedge clk);
        end
        if (p >= 0) begin
            drv_rxd = p[0] ^ flip_par;
            repeat (cur_div) @(negedge clk);
        end
        drv_rxd = stop_v;
        repeat (cur_div) @(negedge clk);
        drv_rxd = 1'b1;
        repeat (cur_div) @(negedge clk);
    endtask

    task automatic expect_rx(input logic [7:0] b, input logic [2:0] e, input string req);
        logic [7:0] d0;
        logic [2:0] e0;
        bit held;
        chk(rx_rdy === 1'b1, req, "rx_rdy", rx_rdy, 1);
        chk(rx_data === b, req, "rx_data", rx_data, b);
        chk(rx_err === e, req, "rx_err", rx_err, e);
        d0 = rx_data;
        e0 = rx_err;
        held = 1;
        repeat (4) begin
            @(negedge clk);
            if (rx_rdy !== 1'b1 || rx_data !== d0 || rx_err !== e0) held = 0;
        end
        chk(held, "R7", "outputs held before ack", held, 1);
        rx_ack = 1'b1;
        @(negedge clk);
        rx_ack = 1'b0;
        chk(rx_rdy === 1'b0, "R7", "rx_rdy after ack", rx_rdy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(txd === 1'b1 && tx_rdy === 1'b1 && rx_rdy === 1'b0, "R1", "outputs in reset",
            {txd, tx_rdy, rx_rdy}, 3'b110);
        rst_n = 1'b1;
        @(negedge clk);
        chk(div_value === 5'd16, "R1", "divisor reset value", div_value, 16);
        chk(txd === 1'b1 && tx_rdy === 1'b1 && rx_rdy === 1'b0, "R1", "outputs after reset",
            {txd, tx_rdy, rx_rdy}, 3'b110);

        // Loopback in every parity mode, plus an unused code (R5)
        loop_en = 1'b1;
        parity_sel = 3'd0; tx_frame(8'hA5, 0); expect_rx(8'hA5, 3'b000, "R4");
        parity_sel = 3'd1; tx_frame(8'h3C, 0); expect_rx(8'h3C, 3'b000, "R5");
        parity_sel = 3'd2; tx_frame(8'h81, 0); expect_rx(8'h81, 3'b000, "R5");
        parity_sel = 3'd3; tx_frame(8'h7E, 1); expect_rx(8'h7E, 3'b000, "R5");
        parity_sel = 3'd3; tx_frame(8'h01, 0); expect_rx(8'h01, 3'b000, "R5");
        parity_sel = 3'd4; tx_frame(8'h00, 0); expect_rx(8'h00, 3'b000, "R5");
        parity_sel = 3'd4; tx_frame(8'hF7, 0); expect_rx(8'hF7, 3'b000, "R5");
        parity_sel = 3'd6; tx_frame(8'h5A, 0); expect_rx(8'h5A, 3'b000, "R5");

        // Runtime divisor change (R2)
        div_we = 1'b1; div_wdata = 5'd10;
        @(negedge clk);
        div_we = 1'b0;
        chk(div_value === 5'd10, "R2", "divisor after write", div_value, 10);
        repeat (3) @(negedge clk);
        chk(div_value === 5'd10, "R2", "divisor holds", div_value, 10);
        cur_div = 10;
        parity_sel = 3'd4; tx_frame(8'hC3, 0); expect_rx(8'hC3, 3'b000, "R2");
        div_we = 1'b1; div_wdata = 5'd16;
        @(negedge clk);
        div_we = 1'b0;
        cur_div = 16;

        // Injected errors on the receive line
        loop_en = 1'b0;
        parity_sel = 3'd3; drive_frame(8'h5A, 1, 1'b1); expect_rx(8'h5A, 3'b010, "R9");
        parity_sel = 3'd1; drive_frame(8'h0F, 1, 1'b1); expect_rx(8'h0F, 3'b010, "R9");
        parity_sel = 3'd2; drive_frame(8'h0E, 0, 1'b1); expect_rx(8'h0E, 3'b000, "R9");
        parity_sel = 3'd0; drive_frame(8'h33, 0, 1'b0); expect_rx(8'h33, 3'b001, "R8");

        // Short low pulse is not a start bit (R6)
        drv_rxd = 1'b0;
        repeat (3) @(negedge clk);
        drv_rxd = 1'b1;
        repeat (12 * cur_div) @(negedge clk);
        chk(rx_rdy === 1'b0, "R6", "glitch produced a byte", rx_rdy, 0);
        drive_frame(8'h96, 0, 1'b1); expect_rx(8'h96, 3'b000, "R6");

        // Overrun (R10)
        drive_frame(8'h11, 0, 1'b1);
        chk(rx_rdy === 1'b1 && rx_data === 8'h11, "R10", "first byte", rx_data, 8'h11);
        drive_frame(8'h22, 0, 1'b1);
        chk(rx_data === 8'h11 && rx_err === 3'b000, "R10", "held byte after overrun",
            {rx_err, rx_data}, {3'b000, 8'h11});
        rx_ack = 1'b1;
        @(negedge clk);
        rx_ack = 1'b0;
        drive_frame(8'h44, 0, 1'b1); expect_rx(8'h44, 3'b100, "R10");
        drive_frame(8'h55, 0, 1'b1); expect_rx(8'h55, 3'b000, "R10");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule